// File: doc/BRIEF.md
# Shared Memory Bus Ownership Arbiter

This block decides which requester drives a shared external memory bus. There are three on-chip masters: a processor port, a DMA engine and a PCI bridge. An off-chip device can also ask for the bus through an asynchronous request / acknowledge pair. Each on-chip master presents a request, a lock flag and a cycle-done strobe. The arbiter looks at requests only when the bus is idle or when the owner finishes a cycle with its lock flag clear. As a result, split narrow-bus accesses, 32-byte line transfers, atomic read-modify-write pairs and DMA dual-address read/write pairs are never broken up.

Handing the bus to the off-chip device takes two steps. First, one cycle in which the control strobes are held at their inactive levels while this side still drives them. Then the cycle in which this side's control output enables turn off and the acknowledge turns on together, so the control lines never float. Taking the bus back mirrors this: the acknowledge drops and the enables turn on together, and strobes start from their inactive levels for one cycle.

Top module: `bus_owner_arb`

## Requirements
- R1: When several requests are pending at an arbitration point, the winner is the off-chip device, then the PCI bridge, then the DMA engine, then the processor. Grant bit positions are: bit0 processor, bit1 DMA, bit2 PCI, bit3 off-chip device.
- R2: `grant` is one-hot or zero at all times, and `owner_valid` is high exactly when a grant bit is set. After reset no grant is given, `ext_ack` is low, `ctl_oe` is high and `strobe_hold` is low.
- R3: The owner changes only when the bus is idle, or in the cycle the current on-chip owner raises its done strobe with its lock flag clear. A higher-priority request that arrives meanwhile waits for that point.
- R4: A done strobe raised while the owner's lock flag is set does not end ownership. This covers split, burst, atomic-pair and dual-address sequences, even with an off-chip request pending.
- R5: The off-chip request passes through a two-stage synchronizer. At the first arbitration point where the synchronized request is high, the next cycle shows no grant and `strobe_hold` high. The cycle after that shows grant bit3 and `ext_ack` high.
- R6: `strobe_hold` is high in the cycle before `ctl_oe` falls and in the cycle `ctl_oe` rises again.
- R7: `ext_ack` rises in the same cycle `ctl_oe` falls, and falls in the same cycle `ctl_oe` rises. The control lines therefore have no undriven interval.
- R8: `ext_ack` stays high, and on-chip requests are ignored, until the synchronized request is seen low. `ext_ack` then falls in the third cycle after the request input falls. On-chip arbitration resumes one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | N_INT | On-chip master requests (bit0 processor, bit1 DMA, bit2 PCI) |
| int_lock | input | N_INT | Lock flag per on-chip master, held for a whole locked sequence |
| int_done | input | N_INT | Cycle-done strobe per on-chip master |
| ext_req_a | input | 1 | Asynchronous off-chip bus request, active high |
| grant | output | N_INT+1 | One-hot current owner, bit N_INT is the off-chip device |
| owner_valid | output | 1 | Some requester owns the bus |
| ext_ack | output | 1 | Registered bus acknowledge to the off-chip device |
| ctl_oe | output | 1 | Output enable of this side's control strobe drivers |
| strobe_hold | output | 1 | Forces control strobes to their inactive levels |

## Verification
The bench builds the block with its defaults: three on-chip masters and two synchronizer stages. This brings all four priority levels and the exact cycle counts of the handover into reach. With two stages, the acknowledge latency from an idle bus is four cycles and the release latency is three, so each handover phase can be checked in its own cycle. The locked case keeps an off-chip request pending while done strobes pulse with the lock set. This shows the deferral rather than just an idle bus.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    PH_INT = 2'd0,
    PH_NEG = 2'd1,
    PH_EXT = 2'd2,
    PH_RET = 2'd3
  } phase_t;

  // highest set bit below n wins; bit order is the priority order
  function automatic int unsigned top_index(input logic [31:0] req, input int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && req[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/int_select.sv
module int_select #(
  parameter int N_INT = 3,
  parameter int IDX_W = 2
) (
  input  logic [N_INT-1:0] req,
  output logic [IDX_W-1:0] pick,
  output logic             pick_valid
);
  import arb_pkg::*;

  logic [31:0] req_wide;

  always_comb begin
    req_wide   = {{(32-N_INT){1'b0}}, req};
    pick_valid = |req;
    pick       = IDX_W'(top_index(req_wide, N_INT));
  end
endmodule

// File: rtl/handover_ctl.sv
module handover_ctl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_seen,
  input  logic            bus_free,
  output arb_pkg::phase_t phase,
  output logic            ext_ack,
  output logic            ctl_oe,
  output logic            strobe_hold
);
  import arb_pkg::*;

  phase_t phase_nx;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_INT:  if (ext_seen && bus_free) phase_nx = PH_NEG;
      PH_NEG:  phase_nx = PH_EXT;
      PH_EXT:  if (!ext_seen) phase_nx = PH_RET;
      default: phase_nx = PH_INT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_INT;
    else        phase <= phase_nx;
  end

  assign ext_ack     = (phase == PH_EXT);
  assign ctl_oe      = (phase != PH_EXT);
  assign strobe_hold = (phase == PH_NEG) || (phase == PH_RET);

  assert_neg_before_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> $past(strobe_hold));
  assert_neg_after_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe) |-> strobe_hold);
  assert_ack_on_with_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ack) |-> $fell(ctl_oe));
  assert_ack_off_with_oe_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_ack) |-> $rose(ctl_oe));
  assert_ack_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ack && ext_seen) |=> ext_ack);
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb #(
  parameter int N_INT       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_INT-1:0]   int_req,
  input  logic [N_INT-1:0]   int_lock,
  input  logic [N_INT-1:0]   int_done,
  input  logic               ext_req_a,
  output logic [N_INT:0]     grant,
  output logic               owner_valid,
  output logic               ext_ack,
  output logic               ctl_oe,
  output logic               strobe_hold
);
  import arb_pkg::*;

  localparam int N_REQ = N_INT + 1;
  localparam int IDX_W = $clog2(N_REQ);
  localparam logic [IDX_W-1:0] EXT_IDX = IDX_W'(N_INT);

  logic             ext_seen;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_valid;
  logic [IDX_W-1:0] own_idx;
  logic             own_valid;
  logic [N_INT-1:0] grant_int;
  logic             cycle_end;
  logic             lock_active;
  logic             bus_free;
  logic [N_INT-1:0] above_mask;
  phase_t           phase;

  req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ext_req_a), .q_sync(ext_seen));

  int_select #(.N_INT(N_INT), .IDX_W(IDX_W)) u_sel (
    .req(int_req), .pick(sel_idx), .pick_valid(sel_valid));

  handover_ctl u_ho (
    .clk(clk), .rst_n(rst_n), .ext_seen(ext_seen), .bus_free(bus_free),
    .phase(phase), .ext_ack(ext_ack), .ctl_oe(ctl_oe), .strobe_hold(strobe_hold));

  always_comb begin
    grant = '0;
    if (own_valid) grant[own_idx] = 1'b1;
  end

  assign owner_valid = own_valid;
  assign grant_int   = grant[N_INT-1:0];
  assign cycle_end   = |(grant_int & int_done & ~int_lock);
  assign lock_active = |(grant_int & int_lock);
  assign bus_free    = !own_valid || cycle_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_valid <= 1'b0;
      own_idx   <= '0;
    end else begin
      case (phase)
        PH_INT: if (bus_free) begin
          if (ext_seen) own_valid <= 1'b0;
          else begin
            own_valid <= sel_valid;
            if (sel_valid) own_idx <= sel_idx;
          end
        end
        PH_NEG: begin
          own_valid <= 1'b1;
          own_idx   <= EXT_IDX;
        end
        PH_EXT: if (!ext_seen) own_valid <= 1'b0;
        default: own_valid <= 1'b0;
      endcase
    end
  end

  // bits above the granted on-chip master, for the priority check
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N_INT; i++) begin
      above_mask[i] = seen;
      seen = seen | grant_int[i];
    end
  end

  assert_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(owner_valid) && !grant[N_INT]) |-> (($past(int_req) & above_mask) == '0));
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (owner_valid == (|grant)));
  assert_owner_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid && !grant[N_INT] && !cycle_end) |=> $stable(grant));
  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> $stable(grant));
  assert_ext_after_negate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant[N_INT]) |-> ($past(strobe_hold) && $past(grant) == '0));
endmodule

// File: tb/sim_bus_owner_arb.sv
module sim_bus_owner_arb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0, lock = '0, done = '0;
  logic       ext = 1'b0;
  logic [3:0] grant;
  logic       ov, ack, oe, sh;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bus_owner_arb u0 (
    .clk(clk), .rst_n(rst_n), .int_req(req), .int_lock(lock), .int_done(done),
    .ext_req_a(ext), .grant(grant), .owner_valid(ov), .ext_ack(ack),
    .ctl_oe(oe), .strobe_hold(sh));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  // grant, then {ack, oe, strobe_hold}, then owner_valid against grant
  task automatic see(input string tag, input logic [3:0] g, input logic a, input logic o, input logic s);
    chk({tag, " grant"}, grant, g);
    chk({tag, " ack/oe/hold"}, {1'b0, ack, oe, sh}, {1'b0, a, o, s});
    chk({tag, " R2 valid"}, {3'b0, ov}, {3'b0, |g});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    see("R2 reset", 4'b0000, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_prio_R1;
    req = 3'b111; tick; see("R1 pci first", 4'b0100, 0, 1, 0);
    done = 3'b100; req = 3'b011; tick; see("R1 dma next", 4'b0010, 0, 1, 0);
    done = 3'b010; req = 3'b001; tick; see("R1 cpu last", 4'b0001, 0, 1, 0);
    done = 3'b001; req = 3'b000; tick; see("R1 idle", 4'b0000, 0, 1, 0);
    done = 3'b000; tick; see("R1 stays idle", 4'b0000, 0, 1, 0);
  endtask

  task automatic t_hold_R3;
    req = 3'b001; tick; see("R3 cpu owns", 4'b0001, 0, 1, 0);
    req = 3'b101; tick; see("R3 cpu keeps", 4'b0001, 0, 1, 0);
    tick; see("R3 cpu still keeps", 4'b0001, 0, 1, 0);
    done = 3'b001; req = 3'b100; tick; see("R3 pci at boundary", 4'b0100, 0, 1, 0);
    done = 3'b100; req = 3'b000; tick; see("R3 released", 4'b0000, 0, 1, 0);
    done = 3'b000;
  endtask

  task automatic t_lock_R4;
    req = 3'b010; tick; see("R4 dma owns", 4'b0010, 0, 1, 0);
    lock = 3'b010; ext = 1'b1;
    for (int k = 0; k < 6; k++) begin
      done = (k % 2 == 1) ? 3'b010 : 3'b000;
      tick; see("R4 locked no release", 4'b0010, 0, 1, 0);
    end
    done = 3'b010; lock = 3'b000; req = 3'b000;
    tick; see("R5 negate cycle", 4'b0000, 0, 1, 1);
    done = 3'b000;
    tick; see("R7 ext on", 4'b1000, 1, 0, 0);
    ext = 1'b0;
    tick; see("R8 ack held 1", 4'b1000, 1, 0, 0);
    tick; see("R8 ack held 2", 4'b1000, 1, 0, 0);
    tick; see("R6 return negated", 4'b0000, 0, 1, 1);
    tick; see("R6 back idle", 4'b0000, 0, 1, 0);
  endtask

  task automatic t_ext_idle_R5;
    ext = 1'b1;
    tick; see("R5 sync 1", 4'b0000, 0, 1, 0);
    tick; see("R5 sync 2", 4'b0000, 0, 1, 0);
    tick; see("R5 negate", 4'b0000, 0, 1, 1);
    tick; see("R5 ack", 4'b1000, 1, 0, 0);
    req = 3'b111;
    repeat (3) begin
      tick; see("R8 internal ignored", 4'b1000, 1, 0, 0);
    end
    ext = 1'b0;
    tick; see("R8 hold a", 4'b1000, 1, 0, 0);
    tick; see("R8 hold b", 4'b1000, 1, 0, 0);
    tick; see("R8 drop ack", 4'b0000, 0, 1, 1);
    tick; see("R8 idle gap", 4'b0000, 0, 1, 0);
    tick; see("R8 resume pci", 4'b0100, 0, 1, 0);
    done = 3'b100; req = 3'b000; tick; see("R8 cleanup", 4'b0000, 0, 1, 0);
    done = 3'b000;
  endtask

  task automatic t_simul_R1;
    req = 3'b001; tick; see("R1 cpu owns", 4'b0001, 0, 1, 0);
    ext = 1'b1; req = 3'b111;
    repeat (3) begin
      tick; see("R3 ext waits boundary", 4'b0001, 0, 1, 0);
    end
    done = 3'b001; req = 3'b110;
    tick; see("R1 ext beats pci", 4'b0000, 0, 1, 1);
    done = 3'b000;
    tick; see("R1 ext granted", 4'b1000, 1, 0, 0);
    ext = 1'b0;
    tick; see("R8 hold c", 4'b1000, 1, 0, 0);
    tick; see("R8 hold d", 4'b1000, 1, 0, 0);
    tick; see("R6 negated on return", 4'b0000, 0, 1, 1);
    tick; see("R8 gap", 4'b0000, 0, 1, 0);
    tick; see("R1 pci after ext", 4'b0100, 0, 1, 0);
    done = 3'b100; req = 3'b000; tick; see("R1 cleanup", 4'b0000, 0, 1, 0);
    done = 3'b000;
  endtask

  initial begin
    t_reset;
    t_prio_R1;
    t_hold_R3;
    t_lock_R4;
    t_ext_idle_R5;
    t_simul_R1;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule